// File: doc/BRIEF.md
# Write-Lockable Control Register Bank

This block is a bank of 8-bit control and status registers that sits behind a simple register port. The port carries an address, write data, a write strobe, a read strobe and registered read data. The serial bus engine in front of the bank turns bus transactions into these strobes. The bank holds the per-channel settings for a four-channel clock fan-out:

- output enables
- sideband-disable masks
- two-bit slew selects

It also holds these shared settings:

- an amplitude code
- four slew-rate option nibbles
- an input-coupling mode and a termination enable
- an automatic-disable enable
- a block-read byte count

Two identification bytes are read-only.

Live inputs can be read back through the same port: the enable-pin states, the sideband-disable states and the active-low loss detector. A sticky loss event flag is cleared by writing 1 to it. Two independent locks freeze all control registers. The first lock, once set, stays set until reset. The second lock flips each time a 1 is written to it. The registers that hold the two locks always stay writable, so the clearable lock can be released even while the bank is frozen.

Top module: `lockable_ctrl_regfile`

## Requirements
- R1: After reset the bank holds these values:
  - all four output enables and all four slew MSBs are 1; masks and slew LSBs are 0.
  - the automatic-disable enable at 0x04 bit 4 is 1; byte count is 7; amplitude code is 6.
  - 0x5B reads 0x60 and 0x5C reads 0xFA; 0x12 bits 7:6 are 0.
  - both locks and the loss event flag are 0.
- R2: The read port:
  - `rdData` takes the value of the addressed register on the first rising edge at which `rdEn` is high.
  - `rdData` holds its value while `rdEn` is low.
- R3: Each per-channel bit sits at a fixed position. Channels 0 and 1 use one address and channels 2 and 3 use another. The address pairs are:
  - output enable: 0x01 / 0x00
  - mask: 0x09 / 0x08
  - enable-pin readback: 0x03 / 0x02
  - sideband-state readback: 0x0C / 0x0B
  - slew MSB: 0x15 / 0x14

  At these addresses, channel 0 is bit 5, channel 1 is bit 1, channel 2 is bit 5 and channel 3 is bit 2. The slew LSBs are at 0x62 (channel 1 bit 7, channel 0 bit 4) and at 0x63 (channel 3 bit 6, channel 2 bit 2). `slewSelect[2c+1:2c]` is {MSB, LSB} of channel c.
- R4: 0x05 reads {revision, vendor} = 0x0A and 0x06 reads 0x04. Writes to these two addresses change nothing.
- R5: The byte count is 0x07 bits 4:0. Bits 7:5 of 0x07 read 0.
- R6: Writing 1 to 0x26 bit 0 sets the sticky lock. No write clears it; only reset does.
- R7: Writing a byte with bit 0 = 1 to 0x27 toggles the clearable lock (0x27 bit 0). Writing bit 0 = 0 leaves it unchanged.
- R8: While either lock is set, writes to every address other than 0x26 and 0x27 are ignored. Writes to 0x26 and 0x27 still take effect. `lockActive` reports that either lock is set.
- R9: The loss event flag (0x27 bit 1, `lossEvent`) is set on every edge where `lossN` is 0. Writing 1 to that bit clears it. A set on the same edge as a clear wins.
- R10: 0x12 bit 0 reads `lossN` live. Bits 7 and 6 of 0x12 are read-write: bit 7 drives `rxAcCouple` and bit 6 drives `rxTermEn`.
- R11: 0x11 bits 7:4 hold the amplitude code. 0x5B holds option 2 in bits 7:4 and option 1 in bits 3:0. 0x5C holds option 4 in bits 7:4 and option 3 in bits 3:0. `slewOptions` is {opt4, opt3, opt2, opt1}.
- R12: Unlisted addresses and reserved bits read 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| pinState | input | 4 | Live enable-pin states, one per channel |
| sbState | input | 4 | Live sideband-disable states, one per channel |
| lossN | input | 1 | Loss detector, 0 = loss present |
| clkEnable | output | 4 | Output enable per channel |
| sbMask | output | 4 | Sideband-disable mask per channel |
| autoDisEn | output | 1 | Automatic output disable enable |
| byteCount | output | 5 | Block-read byte count |
| ampCode | output | 4 | Amplitude code |
| rxAcCouple | output | 1 | Input AC-coupling mode |
| rxTermEn | output | 1 | Input termination enable |
| slewOptions | output | 16 | Four slew option nibbles |
| slewSelect | output | 8 | Two-bit slew select per channel |
| lockActive | output | 1 | Either lock set |
| lossEvent | output | 1 | Sticky loss event flag |

## Verification
The bench releases the clearable lock by writing it a second time. A design that cleared this lock on a write of 0, or that gated its own register with the lock, would stay frozen.

It writes 0 to the sticky lock after setting it. A design that treated this lock like the clearable one would unlock.

It holds `lossN` low across a write-1-to-clear of the event flag. A design where the clear wins would drop the event.

Random writes to reserved holes, to the ID bytes and to reserved bits are checked against reads of every mapped address. This catches aliasing in the decode and bits that are wrongly writable.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NUM_CH = 4;
  localparam int CNT_W = 5;
  localparam int AMP_W = 4;
  localparam int OPT_W = 4;
  localparam int NUM_OPT = 4;
  localparam int OPTS_W = OPT_W * NUM_OPT;

  localparam logic [AW-1:0] ADR_OE_B   = 8'h00;
  localparam logic [AW-1:0] ADR_OE_A   = 8'h01;
  localparam logic [AW-1:0] ADR_PIN_B  = 8'h02;
  localparam logic [AW-1:0] ADR_PIN_A  = 8'h03;
  localparam logic [AW-1:0] ADR_AOD    = 8'h04;
  localparam logic [AW-1:0] ADR_ID_LO  = 8'h05;
  localparam logic [AW-1:0] ADR_ID_HI  = 8'h06;
  localparam logic [AW-1:0] ADR_BCNT   = 8'h07;
  localparam logic [AW-1:0] ADR_MASK_B = 8'h08;
  localparam logic [AW-1:0] ADR_MASK_A = 8'h09;
  localparam logic [AW-1:0] ADR_SBS_B  = 8'h0B;
  localparam logic [AW-1:0] ADR_SBS_A  = 8'h0C;
  localparam logic [AW-1:0] ADR_AMP    = 8'h11;
  localparam logic [AW-1:0] ADR_RX     = 8'h12;
  localparam logic [AW-1:0] ADR_MSB_B  = 8'h14;
  localparam logic [AW-1:0] ADR_MSB_A  = 8'h15;
  localparam logic [AW-1:0] ADR_HLOCK  = 8'h26;
  localparam logic [AW-1:0] ADR_SLOCK  = 8'h27;
  localparam logic [AW-1:0] ADR_OPT_LO = 8'h5B;
  localparam logic [AW-1:0] ADR_OPT_HI = 8'h5C;
  localparam logic [AW-1:0] ADR_LSB_A  = 8'h62;
  localparam logic [AW-1:0] ADR_LSB_B  = 8'h63;

  localparam logic [CNT_W-1:0]  RST_CNT  = 5'd7;
  localparam logic [AMP_W-1:0]  RST_AMP  = 4'd6;
  localparam logic [OPTS_W-1:0] RST_OPTS = 16'hFA60;

  // Channels 0/1 form group A, channels 2/3 group B.
  function automatic logic inGrpA(int ch);
    return ch < 2;
  endfunction

  function automatic logic [2:0] stdBit(int ch);
    case (ch)
      0: return 3'd5;
      1: return 3'd1;
      2: return 3'd5;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] lsbBit(int ch);
    case (ch)
      0: return 3'd4;
      1: return 3'd7;
      2: return 3'd2;
      default: return 3'd6;
    endcase
  endfunction

  function automatic logic [DW-1:0] packStd(logic [NUM_CH-1:0] v, logic wantA);
    logic [DW-1:0] b;
    b = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (inGrpA(ch) == wantA) b[stdBit(ch)] = v[ch];
    return b;
  endfunction

  function automatic logic [DW-1:0] packLsb(logic [NUM_CH-1:0] v, logic wantA);
    logic [DW-1:0] b;
    b = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (inGrpA(ch) == wantA) b[lsbBit(ch)] = v[ch];
    return b;
  endfunction

  typedef struct packed {
    logic [DW-1:0] data;
    logic [AW-1:0] addr;
    logic rd;
    logic known;
    logic wOeA;
    logic wOeB;
    logic wMaskA;
    logic wMaskB;
    logic wMsbA;
    logic wMsbB;
    logic wLsbA;
    logic wLsbB;
    logic wAod;
    logic wCnt;
    logic wAmp;
    logic wRx;
    logic wOptLo;
    logic wOptHi;
    logic wHard;
    logic wSoft;
  } strobes_t;
endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
  import ctrlreg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          lockActive,
  output strobes_t      st
);
  logic wrCtl;

  always_comb begin
    wrCtl = wrEn & ~lockActive;
    st = '0;
    st.data = wrData;
    st.addr = addr;
    st.rd = rdEn;
    st.known = 1'b1;
    case (addr)
      ADR_OE_A:   st.wOeA = wrCtl;
      ADR_OE_B:   st.wOeB = wrCtl;
      ADR_MASK_A: st.wMaskA = wrCtl;
      ADR_MASK_B: st.wMaskB = wrCtl;
      ADR_MSB_A:  st.wMsbA = wrCtl;
      ADR_MSB_B:  st.wMsbB = wrCtl;
      ADR_LSB_A:  st.wLsbA = wrCtl;
      ADR_LSB_B:  st.wLsbB = wrCtl;
      ADR_AOD:    st.wAod = wrCtl;
      ADR_BCNT:   st.wCnt = wrCtl;
      ADR_AMP:    st.wAmp = wrCtl;
      ADR_RX:     st.wRx = wrCtl;
      ADR_OPT_LO: st.wOptLo = wrCtl;
      ADR_OPT_HI: st.wOptHi = wrCtl;
      ADR_HLOCK:  st.wHard = wrEn;
      ADR_SLOCK:  st.wSoft = wrEn;
      ADR_PIN_A, ADR_PIN_B, ADR_SBS_A, ADR_SBS_B,
      ADR_ID_LO, ADR_ID_HI: st.known = 1'b1;
      default:    st.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctrlreg_store.sv
module ctrlreg_store
  import ctrlreg_pkg::*;
#(
  parameter logic [3:0] REV_CODE    = 4'h0,
  parameter logic [3:0] VENDOR_CODE = 4'hA,
  parameter logic [7:0] DEVICE_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [NUM_CH-1:0] pinState,
  input  logic [NUM_CH-1:0] sbState,
  input  logic              lossN,
  output logic [DW-1:0]     rdData,
  output logic [NUM_CH-1:0] clkEnable,
  output logic [NUM_CH-1:0] sbMask,
  output logic              autoDisEn,
  output logic [CNT_W-1:0]  byteCount,
  output logic [AMP_W-1:0]  ampCode,
  output logic              rxAcCouple,
  output logic              rxTermEn,
  output logic [OPTS_W-1:0] slewOptions,
  output logic [2*NUM_CH-1:0] slewSelect,
  output logic              lockActive,
  output logic              lossEvent
);
  logic [NUM_CH-1:0] oeQ, maskQ, msbQ, lsbQ;
  logic              aodQ, acQ, termQ, hardQ, softQ, lossQ;
  logic [CNT_W-1:0]  cntQ;
  logic [AMP_W-1:0]  ampQ;
  logic [OPTS_W-1:0] optQ;
  logic [DW-1:0]     rdQ, rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeQ   <= '1;
      maskQ <= '0;
      msbQ  <= '1;
      lsbQ  <= '0;
      aodQ  <= 1'b1;
      acQ   <= 1'b0;
      termQ <= 1'b0;
      cntQ  <= RST_CNT;
      ampQ  <= RST_AMP;
      optQ  <= RST_OPTS;
      hardQ <= 1'b0;
      softQ <= 1'b0;
      lossQ <= 1'b0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (inGrpA(ch) ? st.wOeA : st.wOeB)     oeQ[ch]   <= st.data[stdBit(ch)];
        if (inGrpA(ch) ? st.wMaskA : st.wMaskB) maskQ[ch] <= st.data[stdBit(ch)];
        if (inGrpA(ch) ? st.wMsbA : st.wMsbB)   msbQ[ch]  <= st.data[stdBit(ch)];
        if (inGrpA(ch) ? st.wLsbA : st.wLsbB)   lsbQ[ch]  <= st.data[lsbBit(ch)];
      end
      if (st.wAod) aodQ <= st.data[4];
      if (st.wCnt) cntQ <= st.data[CNT_W-1:0];
      if (st.wAmp) ampQ <= st.data[DW-1:DW-AMP_W];
      if (st.wRx) begin
        acQ   <= st.data[7];
        termQ <= st.data[6];
      end
      if (st.wOptLo) optQ[DW-1:0]      <= st.data;
      if (st.wOptHi) optQ[OPTS_W-1:DW] <= st.data;
      if (st.wHard && st.data[0]) hardQ <= 1'b1;
      if (st.wSoft && st.data[0]) softQ <= ~softQ;
      // loss presence on this edge outranks a write-1-to-clear
      if (!lossN) lossQ <= 1'b1;
      else if (st.wSoft && st.data[1]) lossQ <= 1'b0;
    end
  end

  always_comb begin
    case (st.addr)
      ADR_OE_A:   rdByte = packStd(oeQ, 1'b1);
      ADR_OE_B:   rdByte = packStd(oeQ, 1'b0);
      ADR_PIN_A:  rdByte = packStd(pinState, 1'b1);
      ADR_PIN_B:  rdByte = packStd(pinState, 1'b0);
      ADR_MASK_A: rdByte = packStd(maskQ, 1'b1);
      ADR_MASK_B: rdByte = packStd(maskQ, 1'b0);
      ADR_SBS_A:  rdByte = packStd(sbState, 1'b1);
      ADR_SBS_B:  rdByte = packStd(sbState, 1'b0);
      ADR_MSB_A:  rdByte = packStd(msbQ, 1'b1);
      ADR_MSB_B:  rdByte = packStd(msbQ, 1'b0);
      ADR_LSB_A:  rdByte = packLsb(lsbQ, 1'b1);
      ADR_LSB_B:  rdByte = packLsb(lsbQ, 1'b0);
      ADR_AOD:    rdByte = {3'b000, aodQ, 4'b0000};
      ADR_ID_LO:  rdByte = {REV_CODE, VENDOR_CODE};
      ADR_ID_HI:  rdByte = DEVICE_CODE;
      ADR_BCNT:   rdByte = {{(DW-CNT_W){1'b0}}, cntQ};
      ADR_AMP:    rdByte = {ampQ, {(DW-AMP_W){1'b0}}};
      ADR_RX:     rdByte = {acQ, termQ, 5'b00000, lossN};
      ADR_HLOCK:  rdByte = {7'b0000000, hardQ};
      ADR_SLOCK:  rdByte = {6'b000000, lossQ, softQ};
      ADR_OPT_LO: rdByte = optQ[DW-1:0];
      ADR_OPT_HI: rdByte = optQ[OPTS_W-1:DW];
      default:    rdByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (st.rd) rdQ <= rdByte;
  end

  assign rdData      = rdQ;
  assign clkEnable   = oeQ;
  assign sbMask      = maskQ;
  assign autoDisEn   = aodQ;
  assign byteCount   = cntQ;
  assign ampCode     = ampQ;
  assign rxAcCouple  = acQ;
  assign rxTermEn    = termQ;
  assign slewOptions = optQ;
  assign lockActive  = hardQ | softQ;
  assign lossEvent   = lossQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    assign slewSelect[2*ch+1:2*ch] = {msbQ[ch], lsbQ[ch]};
  end

  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.rd |=> $stable(rdQ));
  a_r6_hard_sticky: assert property (@(posedge clk) disable iff (!rstN)
    hardQ |=> hardQ);
  a_r7_soft_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (st.wSoft && st.data[0]) |=> (softQ != $past(softQ)));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (hardQ || softQ) |=> ($stable(oeQ) && $stable(maskQ) && $stable(cntQ)
                          && $stable(ampQ) && $stable(optQ) && $stable(msbQ)
                          && $stable(lsbQ)));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    !lossN |=> lossQ);
  a_r12_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.rd && !st.known) |=> (rdQ == '0));
  a_r4_id_read: assert property (@(posedge clk) disable iff (!rstN)
    (st.rd && st.addr == ADR_ID_HI) |=> (rdQ == DEVICE_CODE));
endmodule

// File: rtl/lockable_ctrl_regfile.sv
module lockable_ctrl_regfile
  import ctrlreg_pkg::*;
#(
  parameter logic [3:0] REV_CODE    = 4'h0,
  parameter logic [3:0] VENDOR_CODE = 4'hA,
  parameter logic [7:0] DEVICE_CODE = 8'h04
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   addr,
  input  logic [7:0]   wrData,
  input  logic         wrEn,
  input  logic         rdEn,
  output logic [7:0]   rdData,
  input  logic [3:0]   pinState,
  input  logic [3:0]   sbState,
  input  logic         lossN,
  output logic [3:0]   clkEnable,
  output logic [3:0]   sbMask,
  output logic         autoDisEn,
  output logic [4:0]   byteCount,
  output logic [3:0]   ampCode,
  output logic         rxAcCouple,
  output logic         rxTermEn,
  output logic [15:0]  slewOptions,
  output logic [7:0]   slewSelect,
  output logic         lockActive,
  output logic         lossEvent
);
  strobes_t st;

  ctrlreg_decode u_decode (
    .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .lockActive(lockActive), .st(st)
  );

  ctrlreg_store #(
    .REV_CODE(REV_CODE), .VENDOR_CODE(VENDOR_CODE), .DEVICE_CODE(DEVICE_CODE)
  ) u_store (
    .clk(clk), .rstN(rstN), .st(st), .pinState(pinState), .sbState(sbState),
    .lossN(lossN), .rdData(rdData), .clkEnable(clkEnable), .sbMask(sbMask),
    .autoDisEn(autoDisEn), .byteCount(byteCount), .ampCode(ampCode),
    .rxAcCouple(rxAcCouple), .rxTermEn(rxTermEn), .slewOptions(slewOptions),
    .slewSelect(slewSelect), .lockActive(lockActive), .lossEvent(lossEvent)
  );
endmodule

// File: tb/lockable_ctrl_regfile_test.sv
module lockable_ctrl_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] pinState = '0, sbState = '0;
  logic lossN = 1'b1;
  logic [7:0] rdData;
  logic [3:0] clkEnable, sbMask, ampCode;
  logic autoDisEn, rxAcCouple, rxTermEn, lockActive, lossEvent;
  logic [4:0] byteCount;
  logic [15:0] slewOptions;
  logic [7:0] slewSelect;

  int checks = 0, errors = 0;

  // bench model of the register state
  logic [3:0] mOe, mMask, mMsb, mLsb, mAmp;
  logic mAod, mAc, mTerm, mHard, mSoft, mLoss;
  logic [4:0] mCnt;
  logic [15:0] mOpt;

  lockable_ctrl_regfile uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinState(pinState), .sbState(sbState),
    .lossN(lossN), .clkEnable(clkEnable), .sbMask(sbMask), .autoDisEn(autoDisEn),
    .byteCount(byteCount), .ampCode(ampCode), .rxAcCouple(rxAcCouple),
    .rxTermEn(rxTermEn), .slewOptions(slewOptions), .slewSelect(slewSelect),
    .lockActive(lockActive), .lossEvent(lossEvent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int posStd(int ch);
    int p[4] = '{5, 1, 5, 2};
    return p[ch];
  endfunction
  function automatic int posLsb(int ch);
    int p[4] = '{4, 7, 2, 6};
    return p[ch];
  endfunction
  function automatic bit isKnown(logic [7:0] a);
    case (a)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
      8'h0B, 8'h0C, 8'h11, 8'h12, 8'h14, 8'h15, 8'h26, 8'h27, 8'h5B, 8'h5C,
      8'h62, 8'h63: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] grpByte(logic [3:0] v, bit grpA, bit lsb);
    logic [7:0] b = '0;
    for (int ch = 0; ch < 4; ch++)
      if ((ch < 2) == grpA) b[lsb ? posLsb(ch) : posStd(ch)] = v[ch];
    return b;
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return grpByte(mOe, 0, 0);
      8'h01: return grpByte(mOe, 1, 0);
      8'h02: return grpByte(pinState, 0, 0);
      8'h03: return grpByte(pinState, 1, 0);
      8'h04: return {3'b0, mAod, 4'b0};
      8'h05: return 8'h0A;
      8'h06: return 8'h04;
      8'h07: return {3'b0, mCnt};
      8'h08: return grpByte(mMask, 0, 0);
      8'h09: return grpByte(mMask, 1, 0);
      8'h0B: return grpByte(sbState, 0, 0);
      8'h0C: return grpByte(sbState, 1, 0);
      8'h11: return {mAmp, 4'b0};
      8'h12: return {mAc, mTerm, 5'b0, lossN};
      8'h14: return grpByte(mMsb, 0, 0);
      8'h15: return grpByte(mMsb, 1, 0);
      8'h26: return {7'b0, mHard};
      8'h27: return {6'b0, mLoss, mSoft};
      8'h5B: return mOpt[7:0];
      8'h5C: return mOpt[15:8];
      8'h62: return grpByte(mLsb, 1, 1);
      8'h63: return grpByte(mLsb, 0, 1);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] pick(logic [3:0] old, logic [7:0] d, bit grpA, bit lsb);
    logic [3:0] v = old;
    for (int ch = 0; ch < 4; ch++)
      if ((ch < 2) == grpA) v[ch] = d[lsb ? posLsb(ch) : posStd(ch)];
    return v;
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [7:0] d);
    bit locked = mHard | mSoft;
    if (a == 8'h26) begin
      if (d[0]) mHard = 1'b1;
    end else if (a == 8'h27) begin
      if (d[1]) mLoss = 1'b0;
      if (d[0]) mSoft = ~mSoft;
    end else if (!locked) begin
      case (a)
        8'h00: mOe = pick(mOe, d, 0, 0);
        8'h01: mOe = pick(mOe, d, 1, 0);
        8'h08: mMask = pick(mMask, d, 0, 0);
        8'h09: mMask = pick(mMask, d, 1, 0);
        8'h14: mMsb = pick(mMsb, d, 0, 0);
        8'h15: mMsb = pick(mMsb, d, 1, 0);
        8'h62: mLsb = pick(mLsb, d, 1, 1);
        8'h63: mLsb = pick(mLsb, d, 0, 1);
        8'h04: mAod = d[4];
        8'h07: mCnt = d[4:0];
        8'h11: mAmp = d[7:4];
        8'h12: begin mAc = d[7]; mTerm = d[6]; end
        8'h5B: mOpt[7:0] = d;
        8'h5C: mOpt[15:8] = d;
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    modelWrite(a, d);
    if (!lossN) mLoss = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [7:0] a, string tag);
    logic [7:0] exp;
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(posedge clk);
    exp = expRead(a);
    if (!lossN) mLoss = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic checkOuts(string tag);
    logic [7:0] sel;
    for (int ch = 0; ch < 4; ch++) sel[2*ch +: 2] = {mMsb[ch], mLsb[ch]};
    check({tag, " R3 clkEnable"}, clkEnable, mOe);
    check({tag, " R3 sbMask"}, sbMask, mMask);
    check({tag, " R3 slewSelect"}, slewSelect, sel);
    check({tag, " R5 byteCount"}, byteCount, mCnt);
    check({tag, " R11 ampCode"}, ampCode, mAmp);
    check({tag, " R11 slewOptions"}, slewOptions, mOpt);
    check({tag, " R10 rx"}, {rxAcCouple, rxTermEn}, {mAc, mTerm});
    check({tag, " R8 lockActive"}, lockActive, mHard | mSoft);
    check({tag, " R9 lossEvent"}, lossEvent, mLoss);
    check({tag, " R1 autoDisEn"}, autoDisEn, mAod);
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    mOe = 4'hF; mMask = 4'h0; mMsb = 4'hF; mLsb = 4'h0; mAmp = 4'd6;
    mAod = 1'b1; mAc = 1'b0; mTerm = 1'b0; mHard = 1'b0; mSoft = 1'b0;
    mLoss = 1'b0; mCnt = 5'd7; mOpt = 16'hFA60;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R4 identification bytes
    checkOuts("R1 reset");
    for (int a = 0; a < 256; a++)
      if (isKnown(a[7:0])) doRead(a[7:0], "R1 reset read");

    // random traffic: R3 R5 R10 R11 R12
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, d;
      a = $urandom;
      if ($urandom % 4 != 0) begin
        logic [7:0] list[22] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
          8'h06, 8'h07, 8'h08, 8'h09, 8'h0B, 8'h0C, 8'h11, 8'h12, 8'h14,
          8'h15, 8'h27, 8'h5B, 8'h5C, 8'h62, 8'h63, 8'h07};
        a = list[$urandom % 22];
      end
      if (a == 8'h26) a = 8'h07;
      d = $urandom;
      if (a == 8'h27) d = d & 8'h02;
      @(negedge clk);
      pinState = $urandom; sbState = $urandom;
      if ($urandom % 2 == 0) doWrite(a, d);
      doRead($urandom % 2 == 0 ? a : 8'($urandom), "R12 R3 random read");
    end
    checkOuts("R3 after random");

    // R4 identification bytes ignore writes
    doWrite(8'h05, 8'hFF); doRead(8'h05, "R4 vendor byte");
    doWrite(8'h06, 8'h00); doRead(8'h06, "R4 device byte");
    // R5 upper bits of byte count read 0
    doWrite(8'h07, 8'hFF); doRead(8'h07, "R5 count masked");

    // R2 data appears one edge after the strobe and holds afterwards
    doRead(8'h07, "R2 first read");
    held = rdData;
    @(negedge clk); addr = 8'h05; rdEn = 1'b1; #1;
    check("R2 not yet updated", rdData, held);
    @(negedge clk); rdEn = 1'b0; addr = 8'h07;
    check("R2 updated", rdData, 8'h0A);
    repeat (2) @(negedge clk);
    check("R2 held without strobe", rdData, 8'h0A);

    // R7 clearable lock and R8 freezing
    doWrite(8'h27, 8'h01); doRead(8'h27, "R7 soft lock set");
    doWrite(8'h27, 8'h00); doRead(8'h27, "R7 write 0 no effect");
    doWrite(8'h01, 8'h00); doRead(8'h01, "R8 write ignored while locked");
    doWrite(8'h11, 8'h00); doRead(8'h11, "R8 amp frozen");
    checkOuts("R8 locked");
    doWrite(8'h27, 8'h01); doRead(8'h27, "R7 soft lock released");
    doWrite(8'h01, 8'h00); doRead(8'h01, "R8 write after release");

    // R9 / R10 loss flag and live readback
    @(negedge clk); lossN = 1'b0;
    doRead(8'h12, "R10 live loss low");
    @(negedge clk); lossN = 1'b1;
    doRead(8'h12, "R10 live loss high");
    doRead(8'h27, "R9 event sticky");
    doWrite(8'h27, 8'h02); doRead(8'h27, "R9 event cleared");
    @(negedge clk); lossN = 1'b0;
    doWrite(8'h27, 8'h02);
    @(negedge clk); lossN = 1'b1;
    doRead(8'h27, "R9 set wins over clear");
    checkOuts("R9 flag");
    doWrite(8'h27, 8'h02); doRead(8'h27, "R9 cleared again");

    // R6 sticky lock
    doWrite(8'h26, 8'h01); doRead(8'h26, "R6 hard lock set");
    doWrite(8'h26, 8'h00); doRead(8'h26, "R6 write 0 keeps lock");
    doWrite(8'h00, 8'h00); doRead(8'h00, "R8 hard lock blocks");
    doWrite(8'h27, 8'h01); doRead(8'h27, "R8 soft lock writable under hard");
    doWrite(8'h27, 8'h01); doRead(8'h27, "R7 toggle back");
    doWrite(8'h5B, 8'h12); doRead(8'h5B, "R8 options frozen");
    doRead(8'h26, "R6 still set");
    checkOuts("R6 end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule